// File: doc/BRIEF.md
# Dual-Width Register File with Pointer Pairs

This block is the working register store of a small 8-bit RISC core. It holds thirty-two byte-wide registers. The core reads them through two independent read ports. Each read port returns both the single byte at its index and the 16-bit even/odd pair that contains that index. A single write port updates either one byte or a whole pair on the rising clock edge. Reads are combinational, so an operand fetch, the operation and the result write-back fit in one cycle.

The six highest registers also form three 16-bit address pointers. These are driven straight out of the block so the address unit can use them without going through a read port. The whole file also appears at the bottom 32 addresses of the data space. A load/store path can therefore read or write any register by its plain address through a separate byte-wide port. That port stays inert above the aliased window. When it collides with the core write port on the same register, the core write port takes precedence.

Top module: `gpr_pairfile`

## Requirements
- R1: Each read port returns on its byte output, combinationally, the 8-bit content of the register selected by its 5-bit index.
- R2: Each read port returns on its pair output the 16-bit value {R[idx with bit 0 forced to 1], R[idx with bit 0 forced to 0]}. The low byte comes from the even register, and bit 0 of the index has no effect.
- R3: With wr_en=1 and wr_wide=0, wr_data[7:0] is stored into R[wr_idx] at the rising edge and is visible on the reads from the following cycle. No other register changes.
- R4: With wr_en=1 and wr_wide=1, wr_data[7:0] goes to the even register of the pair and wr_data[15:8] to the odd one. Bit 0 of wr_idx is ignored.
- R5: Both read ports and the write port operate in the same cycle. During the write cycle the reads show the old contents, and in the next cycle they show the new contents. This holds for byte and pair widths.
- R6: ptr_x equals {R27,R26}, ptr_y equals {R29,R28} and ptr_z equals {R31,R30}, with the low byte in the even register.
- R7: For ds_addr below 0x20, ds_rdata equals R[ds_addr] combinationally.
- R8: With ds_we=1 and ds_addr below 0x20, ds_wdata is stored into R[ds_addr] at the rising edge.
- R9: When a core write and a data-space write hit the same register in the same cycle, the core value is stored. When they hit different registers, both values are stored.
- R10: For ds_addr of 0x20 or above, a data-space write changes no register and ds_rdata reads zero.
- R11: While rst_n is low at a rising edge, all 32 registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Register index of read port A |
| rd_a_byte | output | 8 | Byte read by port A |
| rd_a_pair | output | 16 | Register pair read by port A |
| rd_b_idx | input | 5 | Register index of read port B |
| rd_b_byte | output | 8 | Byte read by port B |
| rd_b_pair | output | 16 | Register pair read by port B |
| wr_en | input | 1 | Core write enable |
| wr_wide | input | 1 | 1 selects a 16-bit pair write, 0 a byte write |
| wr_idx | input | 5 | Core write register index |
| wr_data | input | 16 | Core write data (low byte only for byte writes) |
| ds_addr | input | 8 | Data-space byte address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| ptr_x | output | 16 | Pointer formed by R27:R26 |
| ptr_y | output | 16 | Pointer formed by R29:R28 |
| ptr_z | output | 16 | Pointer formed by R31:R30 |

## Verification
The two functions that can coincide are the core write-back and a data-space store. The bench provokes this by driving both enables in one cycle. It uses three cases: a byte write and a store on the same register, a pair write whose odd half is the store target, and writes to two neighbouring registers. One cycle later it reads the affected pair back on a read port and compares it with the core value for overlapping targets, or with both values for disjoint ones. A second overlap is between reading and writing the same register. The bench samples the read outputs before and after the edge to show old and then new data.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int GPR_N  = 32;
    localparam int GPR_DW = 8;
    localparam int GPR_IW = $clog2(GPR_N);

    typedef logic [GPR_DW-1:0] gpr_byte_t;

    typedef struct packed {
        gpr_byte_t [GPR_N-1:0] regs;
    } gpr_state_t;
endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port
    import gpr_pkg::*;
(
    input  gpr_state_t              st,
    input  logic [GPR_IW-1:0]       idx,
    output logic [GPR_DW-1:0]       byte_o,
    output logic [2*GPR_DW-1:0]     pair_o
);
    logic [GPR_IW-1:0] even_idx;
    logic [GPR_IW-1:0] odd_idx;

    always_comb begin
        even_idx = {idx[GPR_IW-1:1], 1'b0};
        odd_idx  = {idx[GPR_IW-1:1], 1'b1};
        byte_o   = st.regs[idx];
        pair_o   = {st.regs[odd_idx], st.regs[even_idx]};
    end
endmodule

// File: rtl/gpr_next.sv
module gpr_next
    import gpr_pkg::*;
(
    input  gpr_state_t              st_q,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_wide,
    input  logic [GPR_IW-1:0]       wr_idx,
    input  logic [2*GPR_DW-1:0]     wr_data,
    input  logic                    ds_we,
    input  logic                    ds_in,
    input  logic [GPR_IW-1:0]       ds_idx,
    input  logic [GPR_DW-1:0]       ds_wdata,
    output gpr_state_t              st_d
);
    logic [GPR_N-1:0] sel_lo;
    logic [GPR_N-1:0] sel_hi;
    logic [GPR_N-1:0] sel_ds;

    for (genvar i = 0; i < GPR_N; i++) begin : g_sel
        localparam logic [GPR_IW-1:0] IDX = GPR_IW'(i);
        assign sel_lo[i] = wr_en && (wr_wide ? (wr_idx[GPR_IW-1:1] == IDX[GPR_IW-1:1] && !IDX[0])
                                             : (wr_idx == IDX));
        assign sel_hi[i] = wr_en && wr_wide && (wr_idx[GPR_IW-1:1] == IDX[GPR_IW-1:1]) && IDX[0];
        assign sel_ds[i] = ds_we && ds_in && (ds_idx == IDX);
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < GPR_N; i++) begin
                if (sel_lo[i])      st_d.regs[i] = wr_data[GPR_DW-1:0];
                else if (sel_hi[i]) st_d.regs[i] = wr_data[2*GPR_DW-1:GPR_DW];
                else if (sel_ds[i]) st_d.regs[i] = ds_wdata;
            end
        end
    end
endmodule

// File: rtl/gpr_pairfile.sv
module gpr_pairfile
    import gpr_pkg::*;
#(
    parameter int DS_AW    = 8,
    parameter int PTR_BASE = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [GPR_IW-1:0]       rd_a_idx,
    output logic [GPR_DW-1:0]       rd_a_byte,
    output logic [2*GPR_DW-1:0]     rd_a_pair,
    input  logic [GPR_IW-1:0]       rd_b_idx,
    output logic [GPR_DW-1:0]       rd_b_byte,
    output logic [2*GPR_DW-1:0]     rd_b_pair,
    input  logic                    wr_en,
    input  logic                    wr_wide,
    input  logic [GPR_IW-1:0]       wr_idx,
    input  logic [2*GPR_DW-1:0]     wr_data,
    input  logic [DS_AW-1:0]        ds_addr,
    input  logic                    ds_we,
    input  logic [GPR_DW-1:0]       ds_wdata,
    output logic [GPR_DW-1:0]       ds_rdata,
    output logic [2*GPR_DW-1:0]     ptr_x,
    output logic [2*GPR_DW-1:0]     ptr_y,
    output logic [2*GPR_DW-1:0]     ptr_z
);
    localparam logic [DS_AW-1:0] DS_LIMIT = DS_AW'(GPR_N);
    localparam int X_LO = PTR_BASE;
    localparam int Y_LO = PTR_BASE + 2;
    localparam int Z_LO = PTR_BASE + 4;

    gpr_state_t        state_d, state_q;
    logic              ds_in;
    logic [GPR_IW-1:0] ds_idx;
    logic [GPR_IW-1:0] wr_even, wr_odd;

    always_comb begin
        ds_in   = ds_addr < DS_LIMIT;
        ds_idx  = ds_addr[GPR_IW-1:0];
        wr_even = {wr_idx[GPR_IW-1:1], 1'b0};
        wr_odd  = {wr_idx[GPR_IW-1:1], 1'b1};
    end

    gpr_next u_next (
        .st_q     (state_q),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_wide  (wr_wide),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .ds_we    (ds_we),
        .ds_in    (ds_in),
        .ds_idx   (ds_idx),
        .ds_wdata (ds_wdata),
        .st_d     (state_d)
    );

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    gpr_rd_port u_rd_a (.st(state_q), .idx(rd_a_idx), .byte_o(rd_a_byte), .pair_o(rd_a_pair));
    gpr_rd_port u_rd_b (.st(state_q), .idx(rd_b_idx), .byte_o(rd_b_byte), .pair_o(rd_b_pair));

    always_comb begin
        ds_rdata = ds_in ? state_q.regs[ds_idx] : '0;
        ptr_x    = {state_q.regs[X_LO+1], state_q.regs[X_LO]};
        ptr_y    = {state_q.regs[Y_LO+1], state_q.regs[Y_LO]};
        ptr_z    = {state_q.regs[Z_LO+1], state_q.regs[Z_LO]};
    end

    assert_byte_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |=> (state_q.regs[$past(wr_idx)] == $past(wr_data[GPR_DW-1:0])));

    assert_pair_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |=>
            ({state_q.regs[$past(wr_odd)], state_q.regs[$past(wr_even)]} == $past(wr_data)));

    assert_ptr_z_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide && wr_even == GPR_IW'(Z_LO)) |=> (ptr_z == $past(wr_data)));

    assert_ds_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && ds_in && !(wr_en && (wr_wide ? (wr_idx[GPR_IW-1:1] == ds_idx[GPR_IW-1:1])
                                               : (wr_idx == ds_idx))))
        |=> (state_q.regs[$past(ds_idx)] == $past(ds_wdata)));

    assert_ds_oob_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_we && !ds_in && !wr_en) |=> $stable(state_q));

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0));
endmodule

// File: tb/sim_gpr_pairfile.sv
module sim_gpr_pairfile;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        we;
        logic        wide;
        logic [4:0]  widx;
        logic [15:0] wdat;
        logic        dwe;
        logic [7:0]  dadr;
        logic [7:0]  ddat;
        logic [4:0]  ridx;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 5'd5,  16'h00A5, 1'b0, 8'h00, 8'h00, 5'd4,  16'hA500, 8'd3},  // R3 byte write
        '{1'b1, 1'b1, 5'd6,  16'h1234, 1'b0, 8'h00, 8'h00, 5'd7,  16'h1234, 8'd2},  // R2/R4 pair, odd read index
        '{1'b1, 1'b1, 5'd27, 16'hBEEF, 1'b0, 8'h00, 8'h00, 5'd26, 16'hBEEF, 8'd4},  // R4 odd write index ignored bit0
        '{1'b0, 1'b0, 5'd0,  16'h0000, 1'b1, 8'h1C, 8'h77, 5'd28, 16'h0077, 8'd8},  // R8 data-space write
        '{1'b0, 1'b0, 5'd0,  16'h0000, 1'b1, 8'h21, 8'hFF, 5'd0,  16'h0000, 8'd10}, // R10 out-of-window store
        '{1'b1, 1'b0, 5'd9,  16'h0011, 1'b1, 8'h09, 8'h99, 5'd8,  16'h1100, 8'd9},  // R9 same register, core wins
        '{1'b1, 1'b1, 5'd30, 16'hC0DE, 1'b1, 8'h1F, 8'h55, 5'd30, 16'hC0DE, 8'd9},  // R9 pair overlaps store
        '{1'b1, 1'b0, 5'd12, 16'h003C, 1'b1, 8'h0D, 8'h4D, 5'd12, 16'h4D3C, 8'd9},  // R9 disjoint, both land
        '{1'b1, 1'b0, 5'd29, 16'h0081, 1'b0, 8'h00, 8'h00, 5'd28, 16'h8177, 8'd3}   // R3 byte into pointer
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [7:0]  rd_a_byte, rd_b_byte, ds_rdata;
    logic [15:0] rd_a_pair, rd_b_pair, ptr_x, ptr_y, ptr_z;
    logic        wr_en = 1'b0, wr_wide = 1'b0, ds_we = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ds_addr = '0, ds_wdata = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_pairfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_byte(rd_a_byte), .rd_a_pair(rd_a_pair),
        .rd_b_idx(rd_b_idx), .rd_b_byte(rd_b_byte), .rd_b_pair(rd_b_pair),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        wr_en = v.we; wr_wide = v.wide; wr_idx = v.widx; wr_data = v.wdat;
        ds_we = v.dwe; ds_addr = v.dadr; ds_wdata = v.ddat;
        @(negedge clk);
        wr_en = 1'b0; ds_we = 1'b0;
        rd_a_idx = v.ridx;
        #1 chk($sformatf("R%0d vector", v.req), rd_a_pair, v.exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ds_addr = 8'h1F;
        #1;
        chk("R11 reset ptr_x", ptr_x, 16'h0000);
        chk("R11 reset pair 0", rd_a_pair, 16'h0000);
        chk("R11 reset ds 0x1F", {8'h00, ds_rdata}, 16'h0000);

        for (int k = 0; k < NVEC; k++) run_vec(VEC[k]);

        @(negedge clk);
        #1;
        chk("R6 ptr_x", ptr_x, 16'hBEEF);
        chk("R6 ptr_y", ptr_y, 16'h8177);
        chk("R6 ptr_z", ptr_z, 16'hC0DE);

        rd_a_idx = 5'd5; rd_b_idx = 5'd7;
        #1;
        chk("R1 byte port A", {8'h00, rd_a_byte}, 16'h00A5);
        chk("R1 byte port B", {8'h00, rd_b_byte}, 16'h0012);

        ds_addr = 8'h1E;
        #1 chk("R7 ds read 0x1E", {8'h00, ds_rdata}, 16'h00DE);
        ds_addr = 8'h25;
        #1 chk("R10 ds read 0x25", {8'h00, ds_rdata}, 16'h0000);

        @(negedge clk);
        rd_a_idx = 5'd5; rd_b_idx = 5'd12;
        wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'd5; wr_data = 16'h005A;
        #1;
        chk("R5 byte old during write", {8'h00, rd_a_byte}, 16'h00A5);
        chk("R5 other port during write", rd_b_pair, 16'h4D3C);
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R5 byte new after edge", {8'h00, rd_a_byte}, 16'h005A);

        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b1; wr_idx = 5'd12; wr_data = 16'hFACE;
        #1 chk("R5 pair old during write", rd_b_pair, 16'h4D3C);
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0;
        #1 chk("R5 pair new after edge", rd_b_pair, 16'hFACE);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ds_addr = 8'h05;
        #1;
        chk("R11 reclear ptr_z", ptr_z, 16'h0000);
        chk("R11 reclear ds 0x05", {8'h00, ds_rdata}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule